// File: doc/BRIEF.md
# Banked maskable interrupt controller

This controller gathers up to 48 interrupt sources into three banks of sixteen. Each bank has a status register and a mask register, and a small register bus reads and writes them. Source `n` sits in bank `n/16` at bit `n%16`. A source counts as pending only while its status bit and its mask bit are both 1. The enabled, pending sources drive two request lines to the processor: a normal request and a fast request. A fixed routing table steers each implemented source to exactly one of the two lines.

There are two kinds of source. Level sources have a status bit that follows the synchronized input. Event sources latch a rising edge of the input and stay pending until software writes to the end-of-interrupt address for that source. Software finds the highest pending bit itself. The block does not encode priority and does not produce vectors.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Source n appears at bit n%16 of bank n/16. Status registers are at 0x0240, 0x1240 and 0x2240, and mask registers are at 0x0280, 0x1280 and 0x2280, for banks 0, 1 and 2. A read returns its data on `bus_rdata` in the cycle after the access.
- R2: After reset, every mask register reads zero and both `irq_o` and `fiq_o` are low.
- R3: A mask register reads back the last value written to its implemented bits. Its unimplemented bits read zero. A mask bit of 1 enables its source.
- R4: The implemented sources are 1, 3, 4 to 18, 28, 29 and 32. Every other source has status and mask bits that always read zero, whatever its input does.
- R5: Sources without an end-of-interrupt address are level sensitive. Their status bit follows the input after a two-flop synchronizer and returns to zero when the input falls.
- R6: Sources with an end-of-interrupt address are event sources: 1, 3, 4, 8, 9, 10, 11, 14, 15 and 16. Each one latches on a rising input edge and holds its status after the input falls. A write of any data to its address clears it. The addresses are 0x0600 for source 1, 0x0640 for 3, 0x07C0 for 4, 0x06C0 for 8, 0x0700 for 9, 0x0740 for 10, 0x0680 for 11, 0x0780 for 14, 0x1600 for 15 and 0x1700 for 16.
- R7: If a new rising edge arrives in the same cycle as an end-of-interrupt write to that source, the source stays pending.
- R8: Sources 1, 3 and 32 drive only `fiq_o`. All other implemented sources drive only `irq_o`.
- R9: Each output is a register that holds the OR of the sources routed to it that are both pending and enabled. A source whose mask bit is 0 never raises an output.
- R10: Writes to a status register have no effect. Reads of undecoded addresses return zero. Writes to undecoded addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 48 | Raw interrupt source inputs, asynchronous |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench latches an event source and lowers its input. It then raises the input again in exactly the cycle of an end-of-interrupt write. A design that lets the clear win would lose that interrupt and read zero. The bench drives inputs on unimplemented sources and writes all ones to the mask registers, to catch a design that leaks phantom bits into status or mask reads. It checks that the fast sources stay off the normal line and the reverse, which exposes any mistake in the routing table. It also writes to status registers and to undecoded addresses, and reads the registers back afterwards, to show that a loose address decode corrupts no state.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 16,
  parameter int ADDR_W    = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BANK_W-1:0]    bus_wdata,
  output logic [BANK_W-1:0]    bus_rdata,
  output logic                 irq_o,
  output logic                 fiq_o
);
  localparam int NSRC = NUM_BANKS * BANK_W;
  localparam int BSEL_W = ADDR_W - 12;
  localparam logic [11:0] STAT_OFS = 12'h240;
  localparam logic [11:0] MASK_OFS = 12'h280;
  localparam logic [NSRC-1:0] IMPL_M = NSRC'(48'h0001_3007_FFFA);
  localparam logic [NSRC-1:0] FAST_M = NSRC'(48'h0001_0000_000A);
  localparam logic [NSRC-1:0] EVT_M  = NSRC'(48'h0000_0001_CF1A);

  function automatic logic [NSRC-1:0] eoi_decode(input logic [ADDR_W-1:0] a);
    logic [NSRC-1:0] v;
    v = '0;
    case (a)
      ADDR_W'(16'h0600): v[1]  = 1'b1;
      ADDR_W'(16'h0640): v[3]  = 1'b1;
      ADDR_W'(16'h07C0): v[4]  = 1'b1;
      ADDR_W'(16'h06C0): v[8]  = 1'b1;
      ADDR_W'(16'h0700): v[9]  = 1'b1;
      ADDR_W'(16'h0740): v[10] = 1'b1;
      ADDR_W'(16'h0680): v[11] = 1'b1;
      ADDR_W'(16'h0780): v[14] = 1'b1;
      ADDR_W'(16'h1600): v[15] = 1'b1;
      ADDR_W'(16'h1700): v[16] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

  logic [NSRC-1:0] sync1_q, sync2_q, prev_q, latch_q, mask_q;
  logic [NSRC-1:0] set_vec, eoi_hit, status, live;
  logic [BSEL_W-1:0] bsel;
  logic stat_sel, mask_sel, bank_ok, wr;

  assign wr       = bus_en & bus_we;
  assign bsel     = bus_addr[ADDR_W-1:12];
  assign bank_ok  = int'(bsel) < NUM_BANKS;
  assign stat_sel = bank_ok && bus_addr[11:0] == STAT_OFS;
  assign mask_sel = bank_ok && bus_addr[11:0] == MASK_OFS;
  assign set_vec  = sync2_q & ~prev_q & EVT_M;
  assign eoi_hit  = wr ? eoi_decode(bus_addr) : '0;
  assign status   = ((sync2_q & ~EVT_M) | latch_q) & IMPL_M;
  assign live     = status & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      sync1_q <= src_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      latch_q <= ((latch_q & ~eoi_hit) | set_vec) & EVT_M;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_q[b*BANK_W +: BANK_W] <= '0;
      else if (wr && mask_sel && int'(bsel) == b)
        mask_q[b*BANK_W +: BANK_W] <= bus_wdata & IMPL_M[b*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      irq_o <= |(live & ~FAST_M);
      fiq_o <= |(live & FAST_M);
      if (bus_en && !bus_we) begin
        if (stat_sel)      bus_rdata <= status[int'(bsel)*BANK_W +: BANK_W];
        else if (mask_sel) bus_rdata <= mask_q[int'(bsel)*BANK_W +: BANK_W];
        else               bus_rdata <= '0;
      end
    end
  end

  a_r6_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit != '0 && (eoi_hit & set_vec) == '0) |=> (latch_q & $past(eoi_hit)) == '0);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((eoi_hit & set_vec) != '0) |=> (latch_q & $past(eoi_hit & set_vec)) == $past(eoi_hit & set_vec));

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_q) == '0) |-> (!irq_o && !fiq_o));

  a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mask_sel && bsel == '0) |=> mask_q[BANK_W-1:0] == $past(bus_wdata & IMPL_M[BANK_W-1:0]));

  a_r8_fast_route: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past((live & FAST_M) != '0));

  a_r10_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && stat_sel) |=> $stable(mask_q));
endmodule

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;
  localparam time CLK_PERIOD = 10ns;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [47:0] src_i = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq_o, fiq_o;
  int n_chk = 0, n_fail = 0;

  banked_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [15:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [15:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic settle(); repeat (5) @(negedge clk); endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R2 irq after reset", {15'b0, irq_o}, 16'h0);
    check("R2 fiq after reset", {15'b0, fiq_o}, 16'h0);
    rd(14'h0280, d); check("R2 mask0 reset", d, 16'h0);
    rd(14'h1280, d); check("R2 mask1 reset", d, 16'h0);
    rd(14'h2280, d); check("R2 mask2 reset", d, 16'h0);
  endtask

  task automatic t_mask_rw();
    logic [15:0] d;
    wr(14'h0280, 16'hFFFF); rd(14'h0280, d); check("R3 mask0 impl bits", d, 16'hFFFA);
    wr(14'h1280, 16'hFFFF); rd(14'h1280, d); check("R3 mask1 impl bits", d, 16'h3007);
    wr(14'h2280, 16'hFFFF); rd(14'h2280, d); check("R3 mask2 impl bits", d, 16'h0001);
    wr(14'h0280, 16'h1234); rd(14'h0280, d); check("R3 mask0 readback", d, 16'h1230);
    wr(14'h0280, 0); wr(14'h1280, 0); wr(14'h2280, 0);
  endtask

  task automatic t_level();
    logic [15:0] d;
    wr(14'h0280, 16'h0020);
    src_i[5] = 1; src_i[17] = 1; settle();
    rd(14'h0240, d); check("R5 level src5 status", d, 16'h0020);
    rd(14'h1240, d); check("R1 src17 in bank1 bit1", d, 16'h0002);
    check("R9 irq from enabled level", {15'b0, irq_o}, 16'h1);
    check("R8 level src not on fiq", {15'b0, fiq_o}, 16'h0);
    src_i[5] = 0; src_i[17] = 0; settle();
    rd(14'h0240, d); check("R5 level src5 falls", d, 16'h0);
    check("R9 irq drops", {15'b0, irq_o}, 16'h0);
    wr(14'h0280, 0);
  endtask

  task automatic t_unimpl();
    logic [15:0] d;
    src_i[2] = 1; src_i[20] = 1; src_i[40] = 1; settle();
    rd(14'h0240, d); check("R4 unimpl bank0", d, 16'h0);
    rd(14'h1240, d); check("R4 unimpl bank1", d, 16'h0);
    rd(14'h2240, d); check("R4 unimpl bank2", d, 16'h0);
    src_i[2] = 0; src_i[20] = 0; src_i[40] = 0; settle();
  endtask

  task automatic t_event();
    logic [15:0] d;
    src_i[8] = 1; settle(); src_i[8] = 0; settle();
    rd(14'h0240, d); check("R6 src8 latched", d, 16'h0100);
    check("R9 masked event keeps irq low", {15'b0, irq_o}, 16'h0);
    wr(14'h0280, 16'h0100); settle();
    check("R9 enabled event raises irq", {15'b0, irq_o}, 16'h1);
    wr(14'h06C0, 16'hABCD); settle();
    rd(14'h0240, d); check("R6 eoi 0x06C0 clears src8", d, 16'h0);
    check("R6 irq drops after eoi", {15'b0, irq_o}, 16'h0);
    src_i[16] = 1; settle(); src_i[16] = 0; settle();
    rd(14'h1240, d); check("R6 src16 latched", d, 16'h0001);
    wr(14'h0600, 0); settle();
    rd(14'h1240, d); check("R6 wrong eoi leaves src16", d, 16'h0001);
    wr(14'h1700, 0); settle();
    rd(14'h1240, d); check("R6 eoi 0x1700 clears src16", d, 16'h0);
    wr(14'h0280, 0);
  endtask

  task automatic t_route();
    logic [15:0] d;
    wr(14'h0280, 16'h0002);
    src_i[1] = 1; settle(); src_i[1] = 0; settle();
    check("R8 src1 on fiq", {15'b0, fiq_o}, 16'h1);
    check("R8 src1 not on irq", {15'b0, irq_o}, 16'h0);
    wr(14'h0600, 0); settle();
    check("R6 eoi 0x0600 drops fiq", {15'b0, fiq_o}, 16'h0);
    wr(14'h0280, 0); wr(14'h2280, 16'h0001);
    src_i[32] = 1; settle();
    rd(14'h2240, d); check("R1 src32 bank2 bit0", d, 16'h0001);
    check("R8 src32 on fiq", {15'b0, fiq_o}, 16'h1);
    check("R8 src32 not on irq", {15'b0, irq_o}, 16'h0);
    src_i[32] = 0; settle(); wr(14'h2280, 0);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    src_i[9] = 1; settle(); src_i[9] = 0; settle();
    @(negedge clk); src_i[9] = 1;
    @(negedge clk);
    wr(14'h0700, 0);
    settle();
    rd(14'h0240, d); check("R7 set beats eoi", d, 16'h0200);
    src_i[9] = 0; settle(); wr(14'h0700, 0); settle();
    rd(14'h0240, d); check("R6 eoi 0x0700 clears src9", d, 16'h0);
  endtask

  task automatic t_readonly();
    logic [15:0] d;
    wr(14'h0240, 16'hFFFF); settle();
    rd(14'h0240, d); check("R10 status write ignored", d, 16'h0);
    wr(14'h0280, 16'h00F0);
    wr(14'h0300, 16'hFFFF); wr(14'h3280, 16'hFFFF);
    rd(14'h0280, d); check("R10 undecoded write no effect", d, 16'h00F0);
    rd(14'h0300, d); check("R10 undecoded read zero", d, 16'h0);
    wr(14'h0280, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_mask_rw(); t_level(); t_unimpl(); t_event();
    t_route(); t_set_wins(); t_readonly();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule